// File: doc/BRIEF.md
# Byte Parity Checker and Generator

This block sits on a 36-bit data path made of four 9-bit lanes. Each lane carries eight data bits and one parity bit. Every word that arrives with `in_valid` is checked against the configured parity rule. The word then leaves one cycle later on `out_word`. When generation is switched on, the block rewrites the parity bits that the rule owns, so the outgoing word carries correct parity even if the incoming word did not. The check itself is always made on the word as it arrived.

Parity can be formed over three scopes:
- one lane at a time;
- pairs of lanes (half-words);
- all four lanes together (the whole word).

The sense of the parity is odd or even. A group's parity bit lives in the parity position of its most significant lane. The error flag has two behaviours:
- In its default form it follows the most recently checked word.
- When latching is enabled it stays set until software writes a 1 to clear it.

A small register interface holds the mode bits and exposes the flag.

Top module: `byte_parity_unit`

## Requirements
- R1: After reset the control register reads 0x00 (byte grouping, odd sense, generation off, latching off), the status register reads 0x00, `perr` is low and `out_valid` is low.
- R2: Each word presented with `in_valid` appears on `out_word` with `out_valid` high exactly one cycle later. Data bits (bits 0..7 of every 9-bit lane, lane k at bits 9k..9k+8) pass through unchanged.
- R3: With control bits [1:0] = 0 (byte grouping), each lane's bit 8 is checked against that lane's eight data bits. A lane in error sets its bit of `out_lane_err`. With odd sense, the nine bits of a correct lane hold an odd number of ones.
- R4: With control bits [1:0] = 1 (half-word grouping), lanes 0 and 1 share one parity bit at word bit 17, and lanes 2 and 3 share one at bit 35. An error is reported on lane 1 or lane 3. Bits 8 and 26 are neither checked nor altered.
- R5: With control bits [1:0] = 2 or 3 (full-word grouping), one parity bit at word bit 35 covers all 32 data bits, and an error is reported on lane 3. Bits 8, 17 and 26 are neither checked nor altered.
- R6: Control bit 2 selects the sense: 0 is odd, 1 is even (a correct group then has an even number of ones including its parity bit).
- R7: With control bit 3 set, the group parity bits of the output word are replaced by the correct parity for the current grouping and sense. `out_lane_err` still reports errors of the incoming word.
- R8: With latching off (control bit 4 = 0), `perr` updates with each output word to show whether that word had any error. Between words it holds, and it is cleared by a 1 written to status bit 0.
- R9: With control bit 4 set, `perr` sets on any word with an error and stays set until a write of 1 to status bit 0 (address 1). A write of 0 leaves it set. An error arriving in the same cycle as a clear wins.
- R10: Reads are combinational. Address 0 returns the five control bits in bits [4:0]. Address 1 returns `perr` in bit 0. All other read bits are 0, and writes to bits [7:5] of the control register are dropped.
- R11: A control write takes effect from the following cycle. A word presented in the same cycle as the write is checked under the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming word qualifier |
| in_word | input | 36 | Incoming word, four 9-bit lanes, parity in bit 8 of each lane |
| out_valid | output | 1 | Outgoing word qualifier, one cycle after `in_valid` |
| out_word | output | 36 | Outgoing word, parity regenerated when enabled |
| out_lane_err | output | 4 | Per-lane parity error of the word on `out_word` |
| perr | output | 1 | Parity error flag, following or latched |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench builds the block with its default parameters: four lanes of eight data bits. With four lanes, every grouping scope is distinct: single lanes, two pairs, and the whole word. That lets the bench hit the lane-ownership corners of half-word and full-word modes, where some parity bits must pass untouched. The bench also covers:
- regeneration of parity on bad words;
- both parity senses;
- the race between an error and a clear, and between a control write and a word in the same cycle.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  typedef enum logic [1:0] {
    GRP_BYTE  = 2'd0,
    GRP_HALF  = 2'd1,
    GRP_WORD  = 2'd2,
    GRP_WORD3 = 2'd3
  } grp_e;

  // control register layout, msb first
  typedef struct packed {
    logic latch_en;
    logic gen_en;
    logic even_sense;
    grp_e grp;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/bpar_regs.sv
module bpar_regs
  import bpar_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic          flag,
  output ctrl_t         ctrl,
  output logic          flag_clr,
  output logic [RW-1:0] reg_rdata
);

  localparam int PAD_C = RW - CTRL_W;

  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  assign ctrl_we = reg_wr & ~reg_addr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl     = ctrl_q;
  assign flag_clr = reg_wr & reg_addr & reg_wdata[0];

  always_comb begin
    if (reg_addr) reg_rdata = {{(RW-1){1'b0}}, flag};
    else          reg_rdata = {{PAD_C{1'b0}}, ctrl_q};
  end

  assert_rdata_pad_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_rdata[RW-1:CTRL_W] == '0);

  assert_ctrl_next_cycle_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl_we |=> ctrl == $past(reg_wdata[CTRL_W-1:0]));

  assert_ctrl_stable_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctrl_we |=> $stable(ctrl));

endmodule

// File: rtl/bpar_group_calc.sv
module bpar_group_calc
  import bpar_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DBITS = 8
) (
  input  logic [LANES*(DBITS+1)-1:0] word,
  input  grp_e                       grp,
  input  logic                       even_sense,
  output logic [LANES-1:0]           top_mask,
  output logic [LANES-1:0]           need_par
);

  localparam int LW   = DBITS + 1;
  localparam int HALF = LANES / 2;

  logic [LANES-1:0] lane_x;
  logic             half_lo_x, half_hi_x, whole_x;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign lane_x[k] = ^word[k*LW +: DBITS];
    end
  endgenerate

  assign half_lo_x = ^lane_x[HALF-1:0];
  assign half_hi_x = ^lane_x[LANES-1:HALF];
  assign whole_x   = ^lane_x;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic raw;
      case (grp)
        GRP_BYTE: begin
          raw         = lane_x[i];
          top_mask[i] = 1'b1;
        end
        GRP_HALF: begin
          raw         = (i < HALF) ? half_lo_x : half_hi_x;
          top_mask[i] = (i == HALF-1) || (i == LANES-1);
        end
        default: begin
          raw         = whole_x;
          top_mask[i] = (i == LANES-1);
        end
      endcase
      // odd sense: parity bit makes the group's count of ones odd
      need_par[i] = raw ^ ~even_sense;
    end
  end

endmodule

// File: rtl/bpar_flag.sv
module bpar_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic valid,
  input  logic err_any,
  input  logic latch_en,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (latch_en)   flag_d = (flag_q & ~clr) | (valid & err_any);
    else if (valid) flag_d = err_any;
    else            flag_d = flag_q & ~clr;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    latch_en && flag && !clr |=> flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    latch_en && valid && err_any |=> flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    clr && !valid |=> !flag);

  assert_follow_word_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !latch_en && valid |=> flag == $past(err_any));

endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import bpar_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DBITS = 8,
  parameter int RW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [LANES*(DBITS+1)-1:0] in_word,
  output logic                       out_valid,
  output logic [LANES*(DBITS+1)-1:0] out_word,
  output logic [LANES-1:0]           out_lane_err,
  output logic                       perr,
  input  logic                       reg_wr,
  input  logic                       reg_addr,
  input  logic [RW-1:0]              reg_wdata,
  output logic [RW-1:0]              reg_rdata
);

  localparam int LW = DBITS + 1;
  localparam int W  = LANES * LW;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rst_meta} <= 2'b00;
    else        {rst_sn, rst_meta} <= {rst_meta, 1'b1};
  end

  ctrl_t            ctrl;
  logic             flag_clr;
  logic             flag;
  logic [LANES-1:0] top_mask, need_par;

  bpar_regs #(.RW(RW)) i_regs (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .flag     (flag),
    .ctrl     (ctrl),
    .flag_clr (flag_clr),
    .reg_rdata(reg_rdata)
  );

  bpar_group_calc #(.LANES(LANES), .DBITS(DBITS)) i_calc (
    .word      (in_word),
    .grp       (ctrl.grp),
    .even_sense(ctrl.even_sense),
    .top_mask  (top_mask),
    .need_par  (need_par)
  );

  // check and regenerate
  logic [W-1:0]     word_d, word_q;
  logic [LANES-1:0] lerr_d, lerr_q;
  logic             vld_q;

  always_comb begin
    word_d = in_word;
    for (int i = 0; i < LANES; i++) begin
      lerr_d[i] = top_mask[i] & (in_word[i*LW + DBITS] != need_par[i]);
      if (ctrl.gen_en && top_mask[i]) word_d[i*LW + DBITS] = need_par[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) vld_q <= 1'b0;
    else         vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q <= '0;
      lerr_q <= '0;
    end else if (in_valid) begin
      word_q <= word_d;
      lerr_q <= lerr_d;
    end
  end

  bpar_flag i_flag (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .valid   (in_valid),
    .err_any (|lerr_d),
    .latch_en(ctrl.latch_en),
    .clr     (flag_clr),
    .flag    (flag)
  );

  assign out_valid    = vld_q;
  assign out_word     = word_q;
  assign out_lane_err = lerr_q;
  assign perr         = flag;

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid == $past(in_valid));

  assert_word_top_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl.grp[1] |-> top_mask == (LANES'(1) << (LANES-1)));

  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    in_valid && (|lerr_d) |=> perr && (|out_lane_err));

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_chk
      assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rst_sn)
        in_valid |=> out_word[k*LW +: DBITS] == $past(in_word[k*LW +: DBITS]));

      assert_nontop_pass_R4: assert property (@(posedge clk) disable iff (!rst_sn)
        in_valid && !top_mask[k] |=> out_word[k*LW + DBITS] == $past(in_word[k*LW + DBITS]));

      assert_no_regen_R7: assert property (@(posedge clk) disable iff (!rst_sn)
        in_valid && !ctrl.gen_en |=> out_word[k*LW + DBITS] == $past(in_word[k*LW + DBITS]));
    end
  endgenerate

endmodule

// File: tb/test_byte_parity_unit.sv
module test_byte_parity_unit;

  localparam int LANES = 4;
  localparam int DBITS = 8;
  localparam int LW    = DBITS + 1;
  localparam int W     = LANES * LW;
  localparam int RW    = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [W-1:0]     in_word;
  logic             out_valid;
  logic [W-1:0]     out_word;
  logic [LANES-1:0] out_lane_err;
  logic             perr;
  logic             reg_wr;
  logic             reg_addr;
  logic [RW-1:0]    reg_wdata;
  logic [RW-1:0]    reg_rdata;

  byte_parity_unit #(.LANES(LANES), .DBITS(DBITS), .RW(RW)) i_byte_parity_unit (
    .clk, .rst_n, .in_valid, .in_word, .out_valid, .out_word, .out_lane_err,
    .perr, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [W-1:0]     w;
    logic [LANES-1:0] le;
    logic             f;
    string            tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  logic [4:0] m_ctrl;
  logic       m_flag;

  // ---------------- reference model, written from the requirements
  function automatic void model(input logic [W-1:0] w, input logic [4:0] c,
                                output logic [W-1:0] o, output logic [LANES-1:0] le);
    int gs;
    gs = (c[1:0] == 2'd0) ? 1 : (c[1:0] == 2'd1) ? LANES/2 : LANES;
    o  = w;
    le = '0;
    for (int k = 0; k < LANES; k++) begin
      if ((k % gs) == gs - 1) begin
        int   cnt;
        logic p;
        cnt = 0;
        for (int j = k - gs + 1; j <= k; j++) cnt += $countones(w[j*LW +: DBITS]);
        p = c[2] ? cnt[0] : ~cnt[0];
        le[k] = (w[k*LW + DBITS] != p);
        if (c[3]) o[k*LW + DBITS] = p;
      end
    end
  endfunction

  function automatic logic [W-1:0] mk(input logic [31:0] d, input logic [3:0] p);
    logic [W-1:0] w;
    for (int k = 0; k < LANES; k++) begin
      w[k*LW +: DBITS]   = d[k*8 +: 8];
      w[k*LW + DBITS]    = p[k];
    end
    return w;
  endfunction

  function automatic logic [W-1:0] good(input logic [31:0] d, input logic [4:0] c);
    logic [W-1:0]     o;
    logic [LANES-1:0] le;
    model(mk(d, 4'h0), c | 5'b01000, o, le);
    return o;
  endfunction

  function automatic logic [W-1:0] bit_at(input int n);
    logic [W-1:0] r;
    r    = '0;
    r[n] = 1'b1;
    return r;
  endfunction

  // ---------------- driver: one cycle of stimulus, pushes expectations
  task automatic step(input bit v, input logic [W-1:0] w, input bit wr,
                      input bit a, input logic [7:0] d, input string tag);
    logic             clr;
    logic [W-1:0]     o;
    logic [LANES-1:0] le;
    @(negedge clk);
    in_valid  = v;
    in_word   = w;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    clr = wr && a && d[0];
    model(w, m_ctrl, o, le);
    if (m_ctrl[4])  m_flag = (m_flag & ~clr) | (v & (|le));
    else if (v)     m_flag = |le;
    else            m_flag = m_flag & ~clr;
    if (v) q.push_back('{w: o, le: le, f: m_flag, tag: tag});
    if (wr && !a) m_ctrl = d[4:0];
  endtask

  task automatic send(input logic [W-1:0] w, input string tag);
    step(1'b1, w, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    step(1'b0, '0, 1'b1, a, d, "wr");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 8'h00, "idle");
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_reg(input bit a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    reg_wr   = 1'b0;
    reg_addr = a;
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  // ---------------- monitor: pops and compares
  always @(posedge clk) begin
    #3;
    if (out_valid) begin
      if (q.size() == 0) begin
        check("R2 unexpected out_valid", 64'(1), 64'(0));
      end else begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " word"}, 64'(out_word), 64'(it.w));
        check({it.tag, " lane_err"}, 64'(out_lane_err), 64'(it.le));
        check({it.tag, " perr"}, 64'(perr), 64'(it.f));
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    m_ctrl = '0; m_flag = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 out_valid", 64'(out_valid), 64'(0));
    check("R1 perr", 64'(perr), 64'(0));
    check_reg(1'b0, 8'h00, "R1 control");
    check_reg(1'b1, 8'h00, "R1 status");

    // R3 byte grouping, odd sense; R2 back-to-back words
    send(good(32'h1234_5678, 5'd0), "R3 good");
    send(good(32'h1234_5678, 5'd0) ^ bit_at(2*LW + DBITS), "R3 lane2 parity flip");
    send(good(32'hFFFF_FFFF, 5'd0) ^ bit_at(5), "R3 lane0 data flip");
    send(good(32'h0000_0000, 5'd0), "R8 clean word clears");
    send(mk(32'hDEAD_BEEF, 4'hF), "R2 arbitrary word");
    idle(2);

    // R8 unlatched flag cleared by write between words
    send(mk(32'h0, 4'h0), "R8 all lanes bad");
    idle(1);
    check("R8 perr held", 64'(perr), 64'(1));
    wr(1'b1, 8'h01);
    idle(1);
    check("R8 perr cleared by write", 64'(perr), 64'(0));

    // R4 half-word grouping
    wr(1'b0, 8'h01);
    send(good(32'hA5A5_0F0F, 5'd1) ^ bit_at(DBITS) ^ bit_at(2*LW + DBITS), "R4 ignored bits");
    send(good(32'hA5A5_0F0F, 5'd1) ^ bit_at(LW + DBITS), "R4 low half bad");
    send(good(32'h0102_0304, 5'd1) ^ bit_at(3*LW + 1), "R4 high half data bad");
    idle(2);

    // R5 full-word grouping, codes 2 and 3
    wr(1'b0, 8'h02);
    send(good(32'h8000_0001, 5'd2) ^ bit_at(DBITS) ^ bit_at(LW + DBITS) ^ bit_at(2*LW + DBITS), "R5 ignored bits");
    send(good(32'h8000_0001, 5'd2) ^ bit_at(3*LW + DBITS), "R5 word bad");
    wr(1'b0, 8'h03);
    send(good(32'h7777_0000, 5'd3) ^ bit_at(LW + 3), "R5 code3 data bad");
    idle(2);

    // R6 even sense
    wr(1'b0, 8'h04);
    send(good(32'h1357_9BDF, 5'd4), "R6 even good");
    send(good(32'h1357_9BDF, 5'd0), "R6 odd word under even");
    idle(2);

    // R7 generation, byte and half-word
    wr(1'b0, 8'h08);
    send(mk(32'hCAFE_F00D, 4'h0), "R7 regen byte");
    send(good(32'h0000_00FF, 5'd0), "R7 regen good in");
    wr(1'b0, 8'h0D);
    send(mk(32'h1111_2222, 4'h5), "R7 regen half even");
    idle(2);

    // R9 latched flag
    wr(1'b0, 8'h10);
    send(good(32'h4242_4242, 5'd0) ^ bit_at(DBITS), "R9 set");
    send(good(32'h4242_4242, 5'd0), "R9 stays after clean");
    idle(1);
    check("R9 perr latched", 64'(perr), 64'(1));
    check_reg(1'b1, 8'h01, "R10 status shows flag");
    wr(1'b1, 8'h00);
    idle(1);
    check("R9 write 0 keeps flag", 64'(perr), 64'(1));
    wr(1'b1, 8'h01);
    idle(1);
    check("R9 write 1 clears", 64'(perr), 64'(0));
    step(1'b1, mk(32'h0, 4'h0), 1'b1, 1'b1, 8'h01, "R9 set wins over clear");
    idle(1);
    check("R9 flag after race", 64'(perr), 64'(1));
    wr(1'b1, 8'h01);
    idle(1);
    check("R9 final clear", 64'(perr), 64'(0));

    // R10 register readback
    wr(1'b0, 8'hFF);
    check_reg(1'b0, 8'h1F, "R10 upper bits dropped");
    wr(1'b0, 8'h00);
    check_reg(1'b0, 8'h00, "R10 control zero");

    // R11 write and word in the same cycle
    w = good(32'h0F0F_0F0F, 5'd0);
    step(1'b1, w, 1'b1, 1'b0, 8'h04, "R11 old settings apply");
    send(w, "R11 new settings apply");
    idle(3);

    check("R2 queue drained", 64'(q.size()), 64'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule